// File: doc/BRIEF.md
# Divider Configuration Port

This block holds the settings that steer a clock synthesizer: a 9-bit feedback divide value, a 2-bit output-divider select and a 3-bit test selector. The settings can be written in two ways. The first is a parallel word, captured while an active-low strobe is low and held from the moment that strobe returns high. The second is a 14-bit serial frame, shifted in on a serial clock and committed by a serial load line. All strobe, clock and data pins are asynchronous to the system clock. They pass through two-flop synchronizers, and edges are detected in the system clock domain.

The parallel strobe takes priority over serial activity. While it is low, the parallel buses drive the divide settings directly and the test selector reads zero. In serial mode, the first bit of a frame lands in the test selector's top bit. A rising edge on the load line commits the frame. While the load line stays high, each serial clock edge shifts the serial data into the feedback divide value and leaves the shift register alone. The last stage of the shift register is brought out as a tap for the test selector.

Top module: `divcfg_port`

## Requirements
- R1: After reset the outputs read fb_div=200, out_sel=0, test_sel=0 and shift_tap=0.
- R2: While pload_n is low, fb_div and out_sel follow par_fb and par_sel within 4 system clocks, and test_sel reads 000.
- R3: After pload_n goes high, fb_div and out_sel keep the last values taken while the strobe was low, and later changes on par_fb or par_sel have no effect.
- R4: With pload_n high and ser_ld low, each rising ser_clk edge shifts ser_dat into a 14-bit register while the settings stay unchanged. shift_tap is bit 13 of that register, so after 14 edges it shows the first bit sent.
- R5: A rising ser_ld edge with pload_n high copies the frame into the settings. The frame is sent first bit first as T2 T1 T0 N1 N0 M8 … M0: the first 3 bits go to test_sel, the next 2 to out_sel and the last 9 to fb_div, each MSB first.
- R6: After ser_ld falls, the settings stay held while a new frame is shifted in.
- R7: While ser_ld is high and pload_n is high, each rising ser_clk edge sets fb_div to {fb_div[7:0], ser_dat}. out_sel, test_sel and the shift register do not change.
- R8: While pload_n is low, ser_clk edges neither change the outputs nor change the shift register.
- R9: A rising ser_ld edge while pload_n is low has no effect; the parallel values and test_sel=0 remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pload_n | input | 1 | Active-low parallel load strobe (asynchronous) |
| par_fb | input | 9 | Parallel feedback divide value |
| par_sel | input | 2 | Parallel output-divider select |
| ser_clk | input | 1 | Serial shift clock (asynchronous, sampled) |
| ser_dat | input | 1 | Serial data |
| ser_ld | input | 1 | Serial load line |
| fb_div | output | 9 | Effective feedback divide value |
| out_sel | output | 2 | Effective output-divider select |
| test_sel | output | 3 | Effective test selector |
| shift_tap | output | 1 | Last stage of the shift register |

## Verification
A shift register that is corrupted by clocks arriving during parallel mode, or by clocks arriving in transparent mode, stays hidden until the next serial commit. The bench therefore re-commits without shifting and compares the settings against the frame it last sent. Wrong priority or wrong hold logic shows on fb_div, out_sel or test_sel within four system clocks of the offending edge, so every check samples a few clocks after each stimulus change.

// File: rtl/divcfg_pkg.sv
`timescale 1ns/1ps
// Shared widths and reset values for the divider configuration port.
package divcfg_pkg;
    localparam int FB_W    = 9;
    localparam int SEL_W   = 2;
    localparam int TST_W   = 3;
    localparam int FRAME_W = TST_W + SEL_W + FB_W;
    localparam int SYNC_STAGES = 2;
    localparam logic [FB_W-1:0]  FB_RST  = FB_W'(200);
    localparam logic [SEL_W-1:0] SEL_RST = '0;
    localparam logic [TST_W-1:0] TST_RST = '0;
endpackage

// File: rtl/divcfg_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent or is held stable around its strobe edges.
module divcfg_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the input through the synchronizer chain.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= INIT;
                else        stg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= {STAGES{INIT}};
                else        stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/divcfg_shreg.sv
`timescale 1ns/1ps
// Serial frame shift register. Shifts one bit in at the LSB when enabled;
// the MSB (first bit received) is the tap. Assumes enable is a one-cycle pulse.
module divcfg_shreg
    import divcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] frame,
    output logic               tap
);
    // Shift in one serial bit per enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        frame <= '0;
        else if (shift_en) frame <= {frame[FRAME_W-2:0], bit_in};
    end

    assign tap = frame[FRAME_W-1];

    // R4 / R7 / R8: the register moves only on an enabled shift
    a_r4_frame_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(frame));
endmodule

// File: rtl/divcfg_hold.sv
`timescale 1ns/1ps
// Settings holder. Priority: parallel mode, then serial commit, then
// transparent shift of the feedback value, else hold.
// Assumes all inputs are already in the clk domain and pulses are one cycle.
module divcfg_hold
    import divcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               par_mode,
    input  logic [FB_W-1:0]    par_fb,
    input  logic [SEL_W-1:0]   par_sel,
    input  logic               commit,
    input  logic               trans_step,
    input  logic               ser_bit,
    input  logic [FRAME_W-1:0] frame,
    output logic [FB_W-1:0]    fb_q,
    output logic [SEL_W-1:0]   sel_q,
    output logic [TST_W-1:0]   tst_q
);
    // Update the held settings according to the active mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_q  <= FB_RST;
            sel_q <= SEL_RST;
            tst_q <= TST_RST;
        end else if (par_mode) begin
            fb_q  <= par_fb;
            sel_q <= par_sel;
            tst_q <= '0;
        end else if (commit) begin
            {tst_q, sel_q, fb_q} <= frame;
        end else if (trans_step) begin
            fb_q <= {fb_q[FB_W-2:0], ser_bit};
        end
    end

    // R2 / R9: parallel mode wins and forces the test selector to zero
    a_r2_par_flow: assert property (@(posedge clk) disable iff (!rst_n)
        par_mode |=> (fb_q == $past(par_fb) && sel_q == $past(par_sel) && tst_q == '0));
    // R5: a commit copies the frame
    a_r5_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_mode && commit) |=> ({tst_q, sel_q, fb_q} == $past(frame)));
    // R7: transparent step touches only the feedback value
    a_r7_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_mode && !commit && trans_step) |=>
        (fb_q == {$past(fb_q[FB_W-2:0]), $past(ser_bit)} && $stable({tst_q, sel_q})));
    // R3 / R6: no event, no change
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_mode && !commit && !trans_step) |=> $stable({tst_q, sel_q, fb_q}));
endmodule

// File: rtl/divcfg_port.sv
`timescale 1ns/1ps
// Divider configuration port: synchronizes the strobe, serial and parallel
// pins, detects serial clock and load edges, and drives the shift register
// and the settings holder. Assumes pins stay stable for several clk cycles.
module divcfg_port
    import divcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pload_n,
    input  logic [FB_W-1:0]  par_fb,
    input  logic [SEL_W-1:0] par_sel,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_ld,
    output logic [FB_W-1:0]  fb_div,
    output logic [SEL_W-1:0] out_sel,
    output logic [TST_W-1:0] test_sel,
    output logic             shift_tap
);
    localparam int CTL_W = 4;
    localparam int PAR_W = FB_W + SEL_W;

    logic [CTL_W-1:0] ctl_s;
    logic [PAR_W-1:0] par_s;
    logic pl_n_s, sclk_s, sld_s, sdat_s;
    logic sclk_d, sld_d;
    logic sclk_rise, sld_rise;
    logic shift_en, commit, trans_step;
    logic [FRAME_W-1:0] frame;

    divcfg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .INIT(4'b0001)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ser_dat, ser_ld, ser_clk, pload_n}), .q(ctl_s));

    divcfg_sync #(.W(PAR_W), .STAGES(SYNC_STAGES), .INIT('0)) u_par_sync (
        .clk(clk), .rst_n(rst_n), .d({par_fb, par_sel}), .q(par_s));

    assign {sdat_s, sld_s, sclk_s, pl_n_s} = ctl_s;

    // Remember the previous serial clock and load levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sld_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            sld_d  <= sld_s;
        end
    end

    assign sclk_rise  = sclk_s & ~sclk_d;
    assign sld_rise   = sld_s & ~sld_d;
    assign shift_en   = pl_n_s & ~sld_s & sclk_rise;
    assign commit     = pl_n_s & sld_rise;
    assign trans_step = pl_n_s & sld_s & sclk_rise;

    divcfg_shreg u_shreg (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(sdat_s),
        .frame(frame), .tap(shift_tap));

    divcfg_hold u_hold (
        .clk(clk), .rst_n(rst_n), .par_mode(~pl_n_s),
        .par_fb(par_s[PAR_W-1:SEL_W]), .par_sel(par_s[SEL_W-1:0]),
        .commit(commit), .trans_step(trans_step), .ser_bit(sdat_s),
        .frame(frame), .fb_q(fb_div), .sel_q(out_sel), .tst_q(test_sel));

    // R8: in parallel mode the shift tap cannot move
    a_r8_tap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_n_s |=> $stable(shift_tap));
    // R4: the shift and transparent paths are mutually exclusive
    a_r4_one_path: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({shift_en, trans_step}) <= 1);
endmodule

// File: tb/divcfg_port_bench.sv
`timescale 1ns/1ps
module divcfg_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pload_n = 1'b1;
    logic [8:0] par_fb = '0;
    logic [1:0] par_sel = '0;
    logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
    logic [8:0] fb_div;
    logic [1:0] out_sel;
    logic [2:0] test_sel;
    logic       shift_tap;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    divcfg_port u_divcfg_port (
        .clk(clk), .rst_n(rst_n), .pload_n(pload_n), .par_fb(par_fb),
        .par_sel(par_sel), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
        .fb_div(fb_div), .out_sel(out_sel), .test_sel(test_sel), .shift_tap(shift_tap));

    // Parallel vectors: {par_fb, par_sel, expected fb_div, expected out_sel}
    localparam int NV = 5;
    localparam logic [NV-1:0][21:0] VEC = {
        {9'd125, 2'd0, 9'd125, 2'd0},
        {9'd350, 2'd1, 9'd350, 2'd1},
        {9'd256, 2'd2, 9'd256, 2'd2},
        {9'd511, 2'd3, 9'd511, 2'd3},
        {9'd0,   2'd0, 9'd0,   2'd0}};

    localparam logic [2:0] A_T = 3'b101;
    localparam logic [1:0] A_N = 2'b10;
    localparam logic [8:0] A_M = 9'd333;
    localparam logic [2:0] B_T = 3'b011;
    localparam logic [1:0] B_N = 2'b01;
    localparam logic [8:0] B_M = 9'd150;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input int m, input int n, input int t);
        chk({req, " fb_div"}, fb_div, m);
        chk({req, " out_sel"}, out_sel, n);
        chk({req, " test_sel"}, test_sel, t);
    endtask

    task automatic ser_bit(input logic b);
        ser_dat = b;
        tick(3);
        ser_clk = 1'b1;
        tick(4);
        ser_clk = 1'b0;
        tick(4);
    endtask

    task automatic send_frame(input logic [13:0] f);
        for (int i = 13; i >= 0; i--) ser_bit(f[i]);
    endtask

    task automatic set_ld(input logic v);
        ser_ld = v;
        tick(6);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        chk_all("R1 reset", 200, 0, 0);
        chk("R1 reset shift_tap", shift_tap, 0);

        // R2: parallel flow-through vectors
        pload_n = 1'b0;
        for (int i = 0; i < NV; i++) begin
            par_fb  = VEC[i][21:13];
            par_sel = VEC[i][12:11];
            tick(5);
            chk_all("R2 parallel", VEC[i][10:2], VEC[i][1:0], 0);
        end

        // R3: capture on strobe release, bus changes ignored afterwards
        par_fb = 9'd277; par_sel = 2'd2;
        tick(5);
        pload_n = 1'b1;
        tick(5);
        par_fb = 9'd17; par_sel = 2'd1;
        tick(6);
        chk_all("R3 held", 277, 2, 0);

        // R4: shifting a frame leaves the settings alone; tap shows first bit
        send_frame({A_T, A_N, A_M});
        chk_all("R4 no change while shifting", 277, 2, 0);
        chk("R4 shift_tap", shift_tap, A_T[2]);

        // R5: commit frame A
        set_ld(1'b1);
        chk_all("R5 commit A", A_M, A_N, A_T);

        // R6: after load falls, a new frame does not disturb the settings
        set_ld(1'b0);
        send_frame({B_T, B_N, B_M});
        chk_all("R6 held after fall", A_M, A_N, A_T);
        chk("R4 shift_tap B", shift_tap, B_T[2]);

        // R5: commit frame B
        set_ld(1'b1);
        chk_all("R5 commit B", B_M, B_N, B_T);

        // R7: transparent steps while load is high
        ser_bit(1'b1); ser_bit(1'b0); ser_bit(1'b1);
        chk_all("R7 transparent", {B_M[5:0], 3'b101}, B_N, B_T);
        set_ld(1'b0);
        set_ld(1'b1);
        chk_all("R7 shift register untouched", B_M, B_N, B_T);
        set_ld(1'b0);

        // R8: serial clocks during parallel mode have no effect
        par_fb = 9'd99; par_sel = 2'd3;
        pload_n = 1'b0;
        tick(5);
        chk_all("R8 parallel value", 99, 3, 0);
        for (int i = 0; i < 5; i++) ser_bit(1'b1);
        chk_all("R8 clocks ignored", 99, 3, 0);
        chk("R8 shift_tap frozen", shift_tap, B_T[2]);

        // R9: serial load during parallel mode has no effect
        set_ld(1'b1);
        chk_all("R9 load ignored", 99, 3, 0);
        set_ld(1'b0);
        pload_n = 1'b1;
        tick(5);
        chk_all("R3 held after R9", 99, 3, 0);
        set_ld(1'b1);
        chk_all("R8 register kept frame B", B_M, B_N, B_T);
        set_ld(1'b0);

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk_all("R1 reset again", 200, 0, 0);
        chk("R1 reset tap", shift_tap, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule